// File: doc/BRIEF.md
# Staggered DRAM Refresh Scheduler

This block times refresh for a memory controller that drives four DRAM banks. Software writes a 16-bit period, and an internal down-counter then expires once every period clocks. Each expiry raises a refresh request towards the memory arbiter. The request stays up until the arbiter grants it. The block then drives per-bank refresh strobes that the row/column waveform logic downstream turns into actual refresh cycles.

A mode input sets how the strobes are spread. In gang mode all four banks strobe together for a single clock. In staggered mode bank 0 strobes first, then bank 1, bank 2 and bank 3, each one clock after the previous one. This limits the peak supply current. The counter keeps running while a request waits. If a second expiry arrives before the first request is granted, a sticky overrun flag is set. A period of zero turns refresh off.

Top module: `refresh_sched`

## Requirements
- R1: After reset, ref_req is 0, all bank strobes are 0, overrun is 0, and the stored period is 0.
- R2: A write of period P (P > 0) restarts the counter. ref_req first rises P clocks after the write edge.
- R3: While the stored period is 0, no expiry occurs and ref_req stays 0.
- R4: Once raised, ref_req stays 1 until it is granted. It drops on the clock edge at which ref_gnt is sampled high and the grant is accepted, unless a new expiry happens on that same edge.
- R5: With stagger_en = 0 at the accepting edge, bank_strobe equals 4'b1111 for exactly one clock, in the cycle after that edge, and then returns to 0.
- R6: With stagger_en = 1 at the accepting edge, bank_strobe takes the values 4'b0001, 4'b0010, 4'b0100, 4'b1000 on four consecutive clocks starting the cycle after that edge (bit n is bank n), and then returns to 0.
- R7: The mode is sampled only at the accepting edge. Changing stagger_en during a sequence does not change the sequence.
- R8: A grant is accepted only while ref_req is 1 and no strobe is active. In any other cycle ref_gnt has no effect on the strobes or on ref_req.
- R9: An expiry while ref_req is 1 and no grant is accepted on that edge sets overrun. overrun then stays 1 until reset.
- R10: The counter reloads on every expiry whether or not a request is pending. Expiries therefore fall every P clocks after the write, independent of grant timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_we | input | 1 | Period register write enable |
| period_wdata | input | 16 | New refresh period in clocks (0 disables) |
| stagger_en | input | 1 | 1 = staggered strobes, 0 = all banks together |
| ref_gnt | input | 1 | Grant from the memory arbiter |
| ref_req | output | 1 | Refresh request to the arbiter |
| bank_strobe | output | 4 | Per-bank refresh strobes, bit n for bank n |
| overrun | output | 1 | Sticky: an expiry found a request still pending |

## Verification
The request rises P clocks after the period write edge, and later requests follow at multiples of P from that same edge. It falls on the edge that accepts a grant. Strobes show up one clock after the accepting edge and then advance one clock at a time. Overrun is visible the clock after the second expiry edge. The bench drives inputs and samples outputs on falling edges. It keeps a count of edges since the last write, so every expected value is compared at the exact falling edge that follows the register update that produces it.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    typedef enum logic {
        SPREAD_GANG    = 1'b0,
        SPREAD_STAGGER = 1'b1
    } spread_mode_e;

    typedef struct packed {
        logic expire;
        logic enabled;
    } timer_evt_t;

    typedef struct packed {
        logic req;
        logic ovr;
    } req_state_t;

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer
    import refresh_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output timer_evt_t       evt
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] count_q;

    always_comb begin
        evt.enabled = (period_q != '0);
        evt.expire  = evt.enabled && (count_q == ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
            count_q  <= '0;
        end else if (wr_en) begin
            period_q <= wr_data;
            count_q  <= wr_data;
        end else if (evt.expire) begin
            count_q  <= period_q;
        end else if (count_q != '0) begin
            count_q  <= count_q - ONE;
        end
    end
endmodule

// File: rtl/refresh_req.sv
module refresh_req
    import refresh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  timer_evt_t evt,
    input  logic       gnt,
    input  logic       busy,
    output logic       accept,
    output req_state_t st
);
    req_state_t st_q;

    always_comb begin
        accept = st_q.req && gnt && !busy;
        st     = st_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.req <= evt.expire || (st_q.req && !accept);
            st_q.ovr <= st_q.ovr || (evt.expire && st_q.req && !accept);
        end
    end
endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
    import refresh_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  spread_mode_e  mode,
    output logic [NB-1:0] strobe,
    output logic          busy
);
    localparam logic [NB-1:0] ALL   = {NB{1'b1}};
    localparam logic [NB-1:0] FIRST = {{(NB-1){1'b0}}, 1'b1};

    logic [NB-1:0] pat_q;
    logic [NB-1:0] pat_d;

    always_comb begin
        busy = (pat_q != '0);
        if (accept) begin
            pat_d = (mode == SPREAD_STAGGER) ? FIRST : ALL;
        end else if (pat_q == ALL) begin
            pat_d = '0;
        end else begin
            pat_d = pat_q << 1;
        end
        strobe = pat_q;
    end

    always_ff @(posedge clk) begin
        if (rst) pat_q <= '0;
        else     pat_q <= pat_d;
    end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refresh_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NB    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             period_we,
    input  logic [CNT_W-1:0] period_wdata,
    input  logic             stagger_en,
    input  logic             ref_gnt,
    output logic             ref_req,
    output logic [NB-1:0]    bank_strobe,
    output logic             overrun
);
    timer_evt_t   evt;
    req_state_t   rst_st;
    logic         accept;
    logic         busy;
    spread_mode_e mode;

    assign mode = stagger_en ? SPREAD_STAGGER : SPREAD_GANG;

    refresh_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (period_we),
        .wr_data (period_wdata),
        .evt     (evt)
    );

    refresh_req u_req (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .gnt    (ref_gnt),
        .busy   (busy),
        .accept (accept),
        .st     (rst_st)
    );

    strobe_seq #(.NB(NB)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .mode   (mode),
        .strobe (bank_strobe),
        .busy   (busy)
    );

    assign ref_req = rst_st.req;
    assign overrun = rst_st.ovr;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          ref_gnt,
    input logic          ref_req,
    input logic [NB-1:0] bank_strobe,
    input logic          overrun
);
    p_req_held_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ref_req) |-> ($past(ref_gnt) || $past(rst)));

    p_gang_one_clock_r5: assert property (@(posedge clk) disable iff (rst)
        (bank_strobe == {NB{1'b1}}) |=> (bank_strobe == '0));

    p_shape_r6: assert property (@(posedge clk) disable iff (rst)
        (bank_strobe == {NB{1'b1}}) || $onehot0(bank_strobe));

    p_stagger_step_r6: assert property (@(posedge clk) disable iff (rst)
        (($countones(bank_strobe) == 1) && !bank_strobe[NB-1])
        |=> (bank_strobe == ($past(bank_strobe) << 1)));

    p_start_after_grant_r8: assert property (@(posedge clk) disable iff (rst)
        (ref_req && ref_gnt && (bank_strobe == '0)) |=> bank_strobe[0]);

    p_idle_without_grant_r8: assert property (@(posedge clk) disable iff (rst)
        ((bank_strobe == '0) && !(ref_req && ref_gnt)) |=> (bank_strobe == '0));

    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
endmodule

bind refresh_sched refresh_sched_chk #(.NB(NB)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_gnt     (ref_gnt),
    .ref_req     (ref_req),
    .bank_strobe (bank_strobe),
    .overrun     (overrun)
);

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        period_we = 1'b0;
    logic [15:0] period_wdata = '0;
    logic        stagger_en = 1'b0;
    logic        ref_gnt = 1'b0;
    logic        ref_req;
    logic [3:0]  bank_strobe;
    logic        overrun;

    int checks = 0;
    int errors = 0;
    int k = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    refresh_sched u_dut (
        .clk          (clk),
        .rst          (rst),
        .period_we    (period_we),
        .period_wdata (period_wdata),
        .stagger_en   (stagger_en),
        .ref_gnt      (ref_gnt),
        .ref_req      (ref_req),
        .bank_strobe  (bank_strobe),
        .overrun      (overrun)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (k=%0d)", tag, what, act, exp, k);
        end
    endtask

    task automatic step();
        @(negedge clk);
        k++;
    endtask

    task automatic write_period(input int p);
        period_we    = 1'b1;
        period_wdata = 16'(p);
        @(negedge clk);
        period_we    = 1'b0;
        k = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ref_gnt = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1", "ref_req", int'(ref_req), 0);
        chk("R1", "strobe", int'(bank_strobe), 0);
        chk("R1", "overrun", int'(overrun), 0);
        // R3 period zero after reset: nothing happens
        for (int i = 0; i < 40; i++) begin
            step();
            chk("R3", "req with zero period", int'(ref_req), 0);
        end

        // Sweep periods and both modes
        for (int p = 6; p <= 13; p++) begin
            for (int m = 0; m < 2; m++) begin
                int d;
                d = p % 3;
                stagger_en = m[0];
                write_period(p);
                for (int i = 0; i < p; i++) begin
                    chk("R2", "req before expiry", int'(ref_req), 0);
                    step();
                end
                chk("R2", "req at P", int'(ref_req), 1);
                for (int i = 0; i < d; i++) begin
                    step();
                    chk("R4", "req held ungranted", int'(ref_req), 1);
                    chk("R8", "no strobe before grant", int'(bank_strobe), 0);
                end
                ref_gnt = 1'b1;
                step();
                ref_gnt = 1'b0;
                chk("R4", "req cleared by grant", int'(ref_req), 0);
                if (m == 0) begin
                    chk("R5", "gang strobe", int'(bank_strobe), 15);
                    step();
                    chk("R5", "gang strobe ends", int'(bank_strobe), 0);
                end else begin
                    for (int b = 0; b < 4; b++) begin
                        chk("R6", "stagger strobe", int'(bank_strobe), 1 << b);
                        step();
                    end
                    chk("R6", "stagger ends", int'(bank_strobe), 0);
                end
                // R10 next expiry still on the P grid
                while (k < 2 * p) begin
                    chk("R10", "req before 2P", int'(ref_req), 0);
                    step();
                end
                chk("R10", "req at 2P", int'(ref_req), 1);
                chk("R9", "no overrun", int'(overrun), 0);
                ref_gnt = 1'b1;
                step();
                ref_gnt = 1'b0;
                write_period(0);
                for (int i = 0; i < 3 * p; i++) begin
                    step();
                    chk("R3", "req after zero write", int'(ref_req), 0);
                end
            end
        end

        // R8 grant with no request is ignored
        ref_gnt = 1'b1;
        step();
        step();
        ref_gnt = 1'b0;
        chk("R8", "strobe from stray grant", int'(bank_strobe), 0);
        chk("R8", "req from stray grant", int'(ref_req), 0);

        // R7/R8 busy-time grant ignored; mode latched at accept
        do_reset();
        stagger_en = 1'b1;
        write_period(3);
        step(); step(); step();
        chk("R2", "req at 3", int'(ref_req), 1);
        ref_gnt = 1'b1;
        step();
        ref_gnt = 1'b0;
        stagger_en = 1'b0;
        chk("R6", "bank0 first", int'(bank_strobe), 1);
        step();
        chk("R7", "mode change ignored", int'(bank_strobe), 2);
        step();
        chk("R10", "req re-raised at 6", int'(ref_req), 1);
        chk("R7", "third strobe", int'(bank_strobe), 4);
        ref_gnt = 1'b1;
        step();
        ref_gnt = 1'b0;
        chk("R8", "busy grant keeps req", int'(ref_req), 1);
        chk("R8", "busy grant no restart", int'(bank_strobe), 8);
        step();
        chk("R8", "sequence ended", int'(bank_strobe), 0);
        chk("R4", "req still pending", int'(ref_req), 1);

        // R9 overrun
        do_reset();
        chk("R1", "overrun cleared by reset", int'(overrun), 0);
        write_period(4);
        while (k < 7) step();
        chk("R9", "overrun before second expiry", int'(overrun), 0);
        chk("R4", "req pending", int'(ref_req), 1);
        step();
        chk("R9", "overrun set", int'(overrun), 1);
        ref_gnt = 1'b1;
        step();
        ref_gnt = 1'b0;
        chk("R4", "req cleared", int'(ref_req), 0);
        chk("R5", "gang after overrun", int'(bank_strobe), 15);
        for (int i = 0; i < 10; i++) begin
            step();
            if (ref_req) begin
                ref_gnt = 1'b1;
            end else begin
                ref_gnt = 1'b0;
            end
        end
        ref_gnt = 1'b0;
        chk("R9", "overrun sticky", int'(overrun), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule